// File: doc/BRIEF.md
# MAC Job Sequencer

This block runs one message-authentication job on a crypto accelerator without software. It is a master on a simple register bus. A single start pulse makes it program the accelerator, in a fixed order, for a 128-bit cipher-block-chaining MAC over a message in external memory. It selects the DMA route, clears stale events, loads a key from a key-store slot and waits for the load to finish. It then writes the IV, the mode word and the length, and launches a DMA channel.

After launch it polls for completion, checks the error flags and turns the DMA route off. It then waits for the saved context to become ready and reads the four tag words. The job ends with a one-cycle done pulse, the tag and an error code. Every poll loop is bounded by a read limit, so a peripheral that never answers ends the job with a timeout instead of hanging it.

Top module: `mac_job_sequencer`

## Requirements
- R1: After reset, `jobBusy`, `jobDone`, `busWr` and `busRd` are 0, `errCode` is 0 and `tagOut` is 0.
- R2: An accepted job begins with three writes in this order: value 2 to the OFS_ALG register, value 1 to the OFS_EVT_CLR register, and the zero-extended `keySlot` to the OFS_KEY_AREA register.
- R3: After the key write, the OFS_KEY_AREA register is read repeatedly until a read returns bit 31 equal to 0. Then the OFS_EVT_STAT register is read once.
- R4: If that status read returns bit 29 equal to 1, the job ends with error code 1 and makes no further bus access.
- R5: Four IV writes follow to OFS_IV+4k, for k = 0 to 3 in order, carrying `ivIn[32k+31:32k]`. Then 0x2000804C is written to OFS_MODE, `msgLen` to OFS_LEN_LO and 0 to OFS_LEN_HI.
- R6: The DMA setup then writes 1 to OFS_CH_EN, `msgAddr` to OFS_CH_ADDR and `msgLen` to OFS_CH_LEN, in that order. Any `msgLen` of 1 or more is accepted, aligned to 16 bytes or not.
- R7: OFS_EVT_STAT is read until bit 0 is 1, then read once more. If that extra read has bit 31 set, the job ends with error code 2.
- R8: Otherwise, 0 is written to OFS_ALG and OFS_MODE is read until bit 30 is 1. Then OFS_TAG+4k is read for k = 0 to 3, each word going to `tagOut[32k+31:32k]`, and the job ends with error code 0.
- R9: If POLL_LIMIT consecutive reads of one poll all fail, the job ends with error code 3. A poll that succeeds on read number POLL_LIMIT does not time out.
- R10: A start with `msgLen` equal to 0 makes no bus access. It raises `jobDone` in the cycle after the start, with error code 4.
- R11: A start pulse while `jobBusy` is 1 is ignored. The running job keeps the parameters it latched at its own start.
- R12: At most one of `busWr` and `busRd` is high at a time. Address, write data and strobe stay unchanged until the cycle in which `busAck` is sampled high.
- R13: `jobDone` is high for exactly one cycle per job. `errCode` holds its value until the next accepted start. `tagOut` is cleared at every accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a job when idle |
| keySlot | input | KEY_W | Key-store slot index |
| ivIn | input | 128 | Initialization vector |
| msgAddr | input | 32 | Message base address in external memory |
| msgLen | input | 32 | Message length in bytes |
| busAddr | output | ADDR_W | Register offset of the current access |
| busWrData | output | 32 | Write data |
| busWr | output | 1 | Write request, held until acknowledged |
| busRd | output | 1 | Read request, held until acknowledged |
| busAck | input | 1 | Access completes in a cycle where this is high |
| busRdData | input | 32 | Read data, valid with `busAck` |
| tagOut | output | 128 | Authentication tag |
| jobDone | output | 1 | One-cycle end-of-job pulse |
| jobBusy | output | 1 | Job in progress |
| errCode | output | 3 | 0 ok, 1 key load, 2 bus/DMA, 3 timeout, 4 zero length |

## Verification
A wrong step register shows up on the bus at once. The access that follows it carries the wrong offset or the wrong data, so the recorded access log differs from the expected log at the first wrong transfer. A poll counter that is wrong or not cleared moves a timeout by one read or more, and the log length and the error code show this when the job ends. A bad tag-word index or a latch that does not clear shows only in `tagOut` at the done pulse. The bench compares the whole log and the tag at every done pulse, and so catches such faults within the job in which they occur.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

  localparam int BLK_WORDS = 4;
  localparam int BLK_W     = 32 * BLK_WORDS;

  typedef enum logic [4:0] {
    ST_ALG_ON, ST_EVT_CLR, ST_KEY_START, ST_KEY_POLL, ST_KEY_CHK,
    ST_IV0, ST_IV1, ST_IV2, ST_IV3, ST_MODE, ST_LEN_LO, ST_LEN_HI,
    ST_CH_EN, ST_CH_ADDR, ST_CH_LEN, ST_DONE_POLL, ST_ERR_CHK,
    ST_ALG_OFF, ST_CTX_POLL, ST_TAG0, ST_TAG1, ST_TAG2, ST_TAG3
  } seqStep_e;

  typedef logic [2:0] jobErr_t;
  localparam jobErr_t ERR_NONE    = 3'd0;
  localparam jobErr_t ERR_KEY     = 3'd1;
  localparam jobErr_t ERR_BUS     = 3'd2;
  localparam jobErr_t ERR_TIMEOUT = 3'd3;
  localparam jobErr_t ERR_LEN     = 3'd4;

  localparam logic [31:0] MODE_CBC_MAC128 = 32'h2000_804C;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadJob;
    logic       capTag;
    logic [1:0] tagIdx;
    logic       incPoll;
    logic       clrPoll;
  } dpStrobe_t;

  function automatic logic isReadStep(input seqStep_e s);
    return s inside {ST_KEY_POLL, ST_KEY_CHK, ST_DONE_POLL, ST_ERR_CHK,
                     ST_CTX_POLL, ST_TAG0, ST_TAG1, ST_TAG2, ST_TAG3};
  endfunction

endpackage

// File: rtl/mac_seq_dpath.sv
module mac_seq_dpath
  import mac_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int KEY_W      = 4,
  parameter int POLL_LIMIT = 64,
  parameter logic [ADDR_W-1:0] OFS_ALG      = 'h000,
  parameter logic [ADDR_W-1:0] OFS_EVT_CLR  = 'h004,
  parameter logic [ADDR_W-1:0] OFS_EVT_STAT = 'h008,
  parameter logic [ADDR_W-1:0] OFS_KEY_AREA = 'h010,
  parameter logic [ADDR_W-1:0] OFS_IV       = 'h020,
  parameter logic [ADDR_W-1:0] OFS_MODE     = 'h030,
  parameter logic [ADDR_W-1:0] OFS_LEN_LO   = 'h034,
  parameter logic [ADDR_W-1:0] OFS_LEN_HI   = 'h038,
  parameter logic [ADDR_W-1:0] OFS_CH_EN    = 'h040,
  parameter logic [ADDR_W-1:0] OFS_CH_ADDR  = 'h044,
  parameter logic [ADDR_W-1:0] OFS_CH_LEN   = 'h048,
  parameter logic [ADDR_W-1:0] OFS_TAG      = 'h050
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  seqStep_e          step,
  input  logic [KEY_W-1:0]  keySlot,
  input  logic [BLK_W-1:0]  ivIn,
  input  logic [31:0]       msgAddr,
  input  logic [31:0]       msgLen,
  input  logic [31:0]       busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWrData,
  output logic [BLK_W-1:0]  tagOut,
  output logic              pollExpired,
  output logic              lenZero
);

  localparam int PCNT_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(POLL_LIMIT - 1);

  logic [KEY_W-1:0]  slotR;
  logic [31:0]       addrR;
  logic [31:0]       lenR;
  logic [31:0]       ivWord  [BLK_WORDS];
  logic [31:0]       tagWord [BLK_WORDS];
  logic [PCNT_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotR <= '0;
      addrR <= '0;
      lenR  <= '0;
    end else if (strobe.loadJob) begin
      slotR <= keySlot;
      addrR <= msgAddr;
      lenR  <= msgLen;
    end
  end

  for (genvar k = 0; k < BLK_WORDS; k++) begin : g_words
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ivWord[k]  <= '0;
        tagWord[k] <= '0;
      end else if (strobe.loadJob) begin
        ivWord[k]  <= ivIn[32*k +: 32];
        tagWord[k] <= '0;
      end else if (strobe.capTag && strobe.tagIdx == 2'(k)) begin
        tagWord[k] <= busRdData;
      end
    end
    assign tagOut[32*k +: 32] = tagWord[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.loadJob || strobe.clrPoll) pollCnt <= '0;
    else if (strobe.incPoll)                       pollCnt <= pollCnt + 1'b1;
  end

  assign pollExpired = (pollCnt == PCNT_LAST);
  assign lenZero     = (msgLen == 32'd0);

  always_comb begin
    busAddr   = OFS_ALG;
    busWrData = '0;
    unique case (step)
      ST_ALG_ON:    begin busAddr = OFS_ALG;      busWrData = 32'd2;          end
      ST_EVT_CLR:   begin busAddr = OFS_EVT_CLR;  busWrData = 32'd1;          end
      ST_KEY_START: begin busAddr = OFS_KEY_AREA; busWrData = 32'(slotR);     end
      ST_KEY_POLL:  busAddr = OFS_KEY_AREA;
      ST_KEY_CHK:   busAddr = OFS_EVT_STAT;
      ST_IV0:       begin busAddr = OFS_IV;                busWrData = ivWord[0]; end
      ST_IV1:       begin busAddr = OFS_IV + ADDR_W'(4);   busWrData = ivWord[1]; end
      ST_IV2:       begin busAddr = OFS_IV + ADDR_W'(8);   busWrData = ivWord[2]; end
      ST_IV3:       begin busAddr = OFS_IV + ADDR_W'(12);  busWrData = ivWord[3]; end
      ST_MODE:      begin busAddr = OFS_MODE;     busWrData = MODE_CBC_MAC128; end
      ST_LEN_LO:    begin busAddr = OFS_LEN_LO;   busWrData = lenR;           end
      ST_LEN_HI:    begin busAddr = OFS_LEN_HI;   busWrData = 32'd0;          end
      ST_CH_EN:     begin busAddr = OFS_CH_EN;    busWrData = 32'd1;          end
      ST_CH_ADDR:   begin busAddr = OFS_CH_ADDR;  busWrData = addrR;          end
      ST_CH_LEN:    begin busAddr = OFS_CH_LEN;   busWrData = lenR;           end
      ST_DONE_POLL: busAddr = OFS_EVT_STAT;
      ST_ERR_CHK:   busAddr = OFS_EVT_STAT;
      ST_ALG_OFF:   begin busAddr = OFS_ALG;      busWrData = 32'd0;          end
      ST_CTX_POLL:  busAddr = OFS_MODE;
      ST_TAG0:      busAddr = OFS_TAG;
      ST_TAG1:      busAddr = OFS_TAG + ADDR_W'(4);
      ST_TAG2:      busAddr = OFS_TAG + ADDR_W'(8);
      ST_TAG3:      busAddr = OFS_TAG + ADDR_W'(12);
      default:      busAddr = OFS_ALG;
    endcase
  end

  // R9
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incPoll |-> !pollExpired);

endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
  import mac_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      lenZero,
  input  logic      busAck,
  input  logic [3:0] rdFlags,   // {bit31, bit30, bit29, bit0} of read data
  input  logic      pollExpired,
  output seqStep_e  step,
  output dpStrobe_t strobe,
  output logic      busWr,
  output logic      busRd,
  output logic      jobBusy,
  output logic      jobDone,
  output jobErr_t   errCode
);

  logic    busyR, doneR;
  jobErr_t errR;
  logic    xfer, pollFail, abort, lastStep, accept;
  jobErr_t abortCode;

  assign accept = !busyR && startPulse;
  assign xfer   = busyR && busAck;

  always_comb begin
    pollFail  = 1'b0;
    abort     = 1'b0;
    abortCode = ERR_NONE;
    unique case (step)
      ST_KEY_POLL:  pollFail = rdFlags[3];
      ST_KEY_CHK:   if (rdFlags[1]) begin abort = 1'b1; abortCode = ERR_KEY; end
      ST_DONE_POLL: pollFail = !rdFlags[0];
      ST_ERR_CHK:   if (rdFlags[3]) begin abort = 1'b1; abortCode = ERR_BUS; end
      ST_CTX_POLL:  pollFail = !rdFlags[2];
      default:      ;
    endcase
    if (pollFail && pollExpired) begin
      abort     = 1'b1;
      abortCode = ERR_TIMEOUT;
    end
  end

  assign lastStep = (step == ST_TAG3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR <= 1'b0;
      doneR <= 1'b0;
      errR  <= ERR_NONE;
      step  <= ST_ALG_ON;
    end else begin
      doneR <= 1'b0;
      if (accept) begin
        if (lenZero) begin
          doneR <= 1'b1;
          errR  <= ERR_LEN;
        end else begin
          busyR <= 1'b1;
          step  <= ST_ALG_ON;
          errR  <= ERR_NONE;
        end
      end else if (xfer) begin
        if (abort) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
          errR  <= abortCode;
        end else if (!pollFail) begin
          if (lastStep) begin
            busyR <= 1'b0;
            doneR <= 1'b1;
            errR  <= ERR_NONE;
          end else begin
            step <= seqStep_e'(step + 5'd1);
          end
        end
      end
    end
  end

  always_comb begin
    strobe.loadJob = accept;
    strobe.capTag  = xfer && (step inside {ST_TAG0, ST_TAG1, ST_TAG2, ST_TAG3});
    strobe.tagIdx  = 2'(step - ST_TAG0);
    strobe.incPoll = xfer && pollFail && !pollExpired;
    strobe.clrPoll = xfer && !pollFail;
  end

  assign busWr   = busyR && !isReadStep(step);
  assign busRd   = busyR && isReadStep(step);
  assign jobBusy = busyR;
  assign jobDone = doneR;
  assign errCode = errR;

  // R12
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busWr, busRd}));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    jobDone |=> !jobDone);

  // R10
  len_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!jobBusy && startPulse && lenZero) |=> (jobDone && errCode == ERR_LEN && !jobBusy));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jobBusy && startPulse && !busAck) |=> $stable(step) && jobBusy);

  // R13
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!jobBusy && !startPulse) |=> $stable(errCode));

endmodule

// File: rtl/mac_job_sequencer.sv
module mac_job_sequencer
  import mac_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int KEY_W      = 4,
  parameter int POLL_LIMIT = 64,
  parameter logic [ADDR_W-1:0] OFS_ALG      = 'h000,
  parameter logic [ADDR_W-1:0] OFS_EVT_CLR  = 'h004,
  parameter logic [ADDR_W-1:0] OFS_EVT_STAT = 'h008,
  parameter logic [ADDR_W-1:0] OFS_KEY_AREA = 'h010,
  parameter logic [ADDR_W-1:0] OFS_IV       = 'h020,
  parameter logic [ADDR_W-1:0] OFS_MODE     = 'h030,
  parameter logic [ADDR_W-1:0] OFS_LEN_LO   = 'h034,
  parameter logic [ADDR_W-1:0] OFS_LEN_HI   = 'h038,
  parameter logic [ADDR_W-1:0] OFS_CH_EN    = 'h040,
  parameter logic [ADDR_W-1:0] OFS_CH_ADDR  = 'h044,
  parameter logic [ADDR_W-1:0] OFS_CH_LEN   = 'h048,
  parameter logic [ADDR_W-1:0] OFS_TAG      = 'h050
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [KEY_W-1:0]  keySlot,
  input  logic [127:0]      ivIn,
  input  logic [31:0]       msgAddr,
  input  logic [31:0]       msgLen,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWrData,
  output logic              busWr,
  output logic              busRd,
  input  logic              busAck,
  input  logic [31:0]       busRdData,
  output logic [127:0]      tagOut,
  output logic              jobDone,
  output logic              jobBusy,
  output logic [2:0]        errCode
);

  seqStep_e  step;
  dpStrobe_t strobe;
  logic      pollExpired, lenZero;
  logic [3:0] rdFlags;

  assign rdFlags = {busRdData[31], busRdData[30], busRdData[29], busRdData[0]};

  mac_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .lenZero    (lenZero),
    .busAck     (busAck),
    .rdFlags    (rdFlags),
    .pollExpired(pollExpired),
    .step       (step),
    .strobe     (strobe),
    .busWr      (busWr),
    .busRd      (busRd),
    .jobBusy    (jobBusy),
    .jobDone    (jobDone),
    .errCode    (errCode)
  );

  mac_seq_dpath #(
    .ADDR_W(ADDR_W), .KEY_W(KEY_W), .POLL_LIMIT(POLL_LIMIT),
    .OFS_ALG(OFS_ALG), .OFS_EVT_CLR(OFS_EVT_CLR), .OFS_EVT_STAT(OFS_EVT_STAT),
    .OFS_KEY_AREA(OFS_KEY_AREA), .OFS_IV(OFS_IV), .OFS_MODE(OFS_MODE),
    .OFS_LEN_LO(OFS_LEN_LO), .OFS_LEN_HI(OFS_LEN_HI), .OFS_CH_EN(OFS_CH_EN),
    .OFS_CH_ADDR(OFS_CH_ADDR), .OFS_CH_LEN(OFS_CH_LEN), .OFS_TAG(OFS_TAG)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .step       (step),
    .keySlot    (keySlot),
    .ivIn       (ivIn),
    .msgAddr    (msgAddr),
    .msgLen     (msgLen),
    .busRdData  (busRdData),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .tagOut     (tagOut),
    .pollExpired(pollExpired),
    .lenZero    (lenZero)
  );

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((busWr || busRd) && !busAck) |=>
      ($stable(busAddr) && $stable(busWrData) && $stable(busWr) && $stable(busRd)));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!jobBusy && !busWr && !busRd && !jobDone));

endmodule

// File: tb/test_mac_job_sequencer.sv
`timescale 1ns/1ps
module test_mac_job_sequencer;

  localparam int LIM = 64;
  localparam logic [11:0] A_ALG = 12'h000, A_EVC = 12'h004, A_EVS = 12'h008,
    A_KEY = 12'h010, A_IV = 12'h020, A_MODE = 12'h030, A_LLO = 12'h034,
    A_LHI = 12'h038, A_CEN = 12'h040, A_CAD = 12'h044, A_CLN = 12'h048,
    A_TAG = 12'h050;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rstN, startPulse, busWr, busRd, busAck, jobDone, jobBusy;
  logic [3:0]   keySlot;
  logic [127:0] ivIn, tagOut;
  logic [31:0]  msgAddr, msgLen, busWrData, busRdData;
  logic [11:0]  busAddr;
  logic [2:0]   errCode;

  mac_job_sequencer i_mac_job_sequencer (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .keySlot(keySlot),
    .ivIn(ivIn), .msgAddr(msgAddr), .msgLen(msgLen), .busAddr(busAddr),
    .busWrData(busWrData), .busWr(busWr), .busRd(busRd), .busAck(busAck),
    .busRdData(busRdData), .tagOut(tagOut), .jobDone(jobDone),
    .jobBusy(jobBusy), .errCode(errCode)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // peripheral model state
  int keyLeft, doneLeft, ctxLeft, waitCnt;
  bit keyErrB, dmaErrB, dmaOn, ctxFlag;
  logic [31:0] tagW [4];
  logic [44:0] logMem [128];
  logic [44:0] expMem [128];
  int logN, expN;
  logic [2:0] expErr;

  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0; busRdData <= '0; waitCnt = 0;
    end else if (busAck) begin
      busAck <= 1'b0;
    end else if (busWr || busRd) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        busAck  <= 1'b1;
        waitCnt = $urandom % 4;
        if (logN < 128) logMem[logN] = {busRd, busAddr, busRd ? 32'd0 : busWrData};
        logN++;
        if (busWr) begin
          if (busAddr == A_CLN) dmaOn = 1;
          if (busAddr == A_ALG && busWrData == 0 && dmaOn) ctxFlag = 1;
          busRdData <= '0;
        end else begin
          logic [31:0] v;
          v = '0;
          if (busAddr == A_KEY) begin
            if (keyLeft > 0) begin keyLeft--; v = 32'h8000_0000; end
          end else if (busAddr == A_EVS) begin
            v = {dmaErrB, 1'b0, keyErrB, 28'd0, 1'b0};
            if (dmaOn) begin
              if (doneLeft > 0) doneLeft--;
              else v[0] = 1'b1;
            end
          end else if (busAddr == A_MODE) begin
            if (ctxFlag) begin
              if (ctxLeft > 0) ctxLeft--;
              else v = 32'h4000_0000;
            end
          end else if (busAddr >= A_TAG && busAddr < A_TAG + 16) begin
            v = tagW[(busAddr - A_TAG) >> 2];
            ctxFlag = 0;
          end
          busRdData <= v;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic addE(input bit rd, input logic [11:0] a, input logic [31:0] d);
    if (expN < 128) expMem[expN] = {rd, a, rd ? 32'd0 : d};
    expN++;
  endtask

  // expected access list and result, from the requirements
  task automatic buildExp(input int kb, db, cb, input bit ke, de,
                          input logic [3:0] slot, input logic [127:0] iv,
                          input logic [31:0] ad, ln);
    expN = 0;
    addE(0, A_ALG, 2); addE(0, A_EVC, 1); addE(0, A_KEY, 32'(slot));
    if (kb >= LIM) begin
      for (int i = 0; i < LIM; i++) addE(1, A_KEY, 0);
      expErr = 3; return;
    end
    for (int i = 0; i <= kb; i++) addE(1, A_KEY, 0);
    addE(1, A_EVS, 0);
    if (ke) begin expErr = 1; return; end
    for (int k = 0; k < 4; k++) addE(0, A_IV + 12'(4*k), iv[32*k +: 32]);
    addE(0, A_MODE, 32'h2000_804C); addE(0, A_LLO, ln); addE(0, A_LHI, 0);
    addE(0, A_CEN, 1); addE(0, A_CAD, ad); addE(0, A_CLN, ln);
    if (db >= LIM) begin
      for (int i = 0; i < LIM; i++) addE(1, A_EVS, 0);
      expErr = 3; return;
    end
    for (int i = 0; i <= db; i++) addE(1, A_EVS, 0);
    addE(1, A_EVS, 0);
    if (de) begin expErr = 2; return; end
    addE(0, A_ALG, 0);
    if (cb >= LIM) begin
      for (int i = 0; i < LIM; i++) addE(1, A_MODE, 0);
      expErr = 3; return;
    end
    for (int i = 0; i <= cb; i++) addE(1, A_MODE, 0);
    for (int k = 0; k < 4; k++) addE(1, A_TAG + 12'(4*k), 0);
    expErr = 0;
  endtask

  task automatic runJob(input int kb, db, cb, input bit ke, de,
                        input logic [31:0] ln, input int injectAt, input string req);
    logic [3:0] slot; logic [127:0] iv; logic [31:0] ad; logic [127:0] expTag;
    int n, bad; bit busyAtInject;
    slot = 4'($urandom); ad = $urandom;
    iv = {$urandom, $urandom, $urandom, $urandom};
    for (int k = 0; k < 4; k++) tagW[k] = $urandom;
    keyLeft = kb; doneLeft = db; ctxLeft = cb; keyErrB = ke; dmaErrB = de;
    dmaOn = 0; ctxFlag = 0; logN = 0;
    if (ln == 0) begin expN = 0; expErr = 4; end
    else buildExp(kb, db, cb, ke, de, slot, iv, ad, ln);
    expTag = (expErr == 0) ? {tagW[3], tagW[2], tagW[1], tagW[0]} : '0;
    @(negedge clk);
    keySlot = slot; ivIn = iv; msgAddr = ad; msgLen = ln; startPulse = 1;
    @(negedge clk);
    startPulse = 0;
    n = 0; busyAtInject = 0;
    while (!jobDone && n < 5000) begin
      @(negedge clk); n++;
      if (injectAt > 0 && n == injectAt) begin
        busyAtInject = jobBusy;
        startPulse = 1; msgLen = 0; msgAddr = ~ad; ivIn = ~iv; keySlot = ~slot;
      end else startPulse = 0;
    end
    startPulse = 0;
    chk(jobDone, "R13", "done seen", 128'(n), 128'(0));
    chk(errCode == expErr, req, "error code", 128'(errCode), 128'(expErr));
    bad = -1;
    for (int i = 0; i < expN && i < 128; i++)
      if (bad < 0 && (i >= logN || logMem[i] !== expMem[i])) bad = i;
    if (bad < 0 && logN != expN) bad = (logN < expN) ? logN : expN;
    if (bad < 0) chk(1, req, "access log", 0, 0);
    else chk(0, req, $sformatf("access log entry %0d (n=%0d exp n=%0d)", bad, logN, expN),
             (bad < logN && bad < 128) ? 128'(logMem[bad]) : 128'(0),
             (bad < expN && bad < 128) ? 128'(expMem[bad]) : 128'(0));
    chk(tagOut == expTag, (expErr == 0) ? "R8" : "R13", "tag", tagOut, expTag);
    if (ln == 0) chk(n == 0, "R10", "done one cycle after start", 128'(n), 0);
    if (injectAt > 0) chk(busyAtInject, "R11", "busy at second start", 128'(busyAtInject), 1);
    @(negedge clk);
    chk(!jobDone && errCode == expErr, "R13", "pulse ends, code held",
        {jobDone, 3'(errCode)}, {1'b0, expErr});
    repeat (3) @(negedge clk);
    chk(logN == expN && !jobDone, "R11", "no extra activity", 128'(logN), 128'(expN));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R13 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7301));
    rstN = 0; startPulse = 0; keySlot = 0; ivIn = 0; msgAddr = 0; msgLen = 0; logN = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(!jobBusy && !jobDone && !busWr && !busRd && errCode == 0 && tagOut == 0,
        "R1", "reset state", {jobBusy, jobDone, busWr, busRd, errCode}, 0);

    // directed: plain job, immediate answers (R2 R3 R5 R6 R7 R8)
    runJob(0, 0, 0, 0, 0, 32'd64, 0, "R2");
    runJob(3, 2, 1, 0, 0, 32'd17, 0, "R5");        // unaligned length, R6
    runJob(0, 0, 0, 0, 0, 32'd1, 0, "R6");         // minimum length
    runJob(2, 0, 0, 1, 0, 32'd32, 0, "R4");        // key-load error
    runJob(0, 4, 0, 0, 1, 32'd48, 0, "R7");        // bus/DMA error
    runJob(LIM, 0, 0, 0, 0, 32'd16, 0, "R9");      // key poll timeout
    runJob(LIM-1, 0, 0, 0, 0, 32'd16, 0, "R9");    // succeeds on last allowed read
    runJob(0, LIM, 0, 0, 0, 32'd16, 0, "R9");      // completion timeout
    runJob(0, 0, LIM, 0, 0, 32'd16, 0, "R9");      // context-ready timeout
    runJob(0, 0, LIM-1, 0, 0, 32'd99, 0, "R3");
    runJob(0, 0, 0, 0, 0, 32'd0, 0, "R10");        // zero length
    runJob(1, 3, 2, 0, 0, 32'd200, 12, "R11");     // start while busy
    runJob(0, 1, 0, 0, 0, 32'd40, 30, "R11");

    // random jobs
    for (int j = 0; j < 24; j++) begin
      int r;
      r = $urandom % 10;
      runJob($urandom % 6, $urandom % 6, $urandom % 6, r == 0, r == 1,
             32'($urandom % 5000) + 32'd1, 0, (r == 0) ? "R4" : (r == 1) ? "R7" : "R8");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule